// File: doc/BRIEF.md
# Power Domain Sequencer

This block switches a set of power domains on and off when a mode controller asks for a change between a low-power standby state and a run state. Domain 0 stays supplied at all times. Domain 1 is always removed in standby. Each higher domain is a retention RAM extension with its own keep bit. A set keep bit keeps that domain supplied through standby. A clear keep bit lets it go down.

Every domain that changes state gets three controls: a clock enable, an active-low reset and a supply switch. The block drives them one step per cycle, in a fixed order. When powering up, it waits for a per-domain voltage-good input before it enables the clock. A programmable limit bounds that wait. When the limit is reached, the block sets an error flag and leaves the domain held in reset. A single done pulse marks the end of each request. A derived output reports how much retention RAM the current keep bits preserve in standby.

Top module: `pwr_dom_seq`

## Requirements
- R1: After reset, every domain has supply on, clock enabled and reset released. In the same state done, err and busy are low, the keep bits are all set and the timeout limit is TMO_INIT.
- R2: Domain 0 outputs never change.
- R3: On a standby request, domain 1 is powered down. Each domain d>=2 is powered down exactly when cfg_keep[d-2] is 0.
- R4: Powering a domain down takes three steps in consecutive cycles: clock disabled, then reset asserted (dom_rst_n low), then supply switched off. Domains are handled one at a time, from the highest index downward.
- R5: On a run request, every domain whose reset is asserted is brought up in ascending index order. The supply is switched on (if it was off), then the block waits for pwr_ok, then enables the clock, then releases the reset.
- R6: A run request never powers any domain down, whatever the keep bits hold.
- R7: If pwr_ok stays low for cfg_limit+1 wait cycles, err is set. The domain is then left with supply on, clock off and reset asserted, and sequencing continues with the next domain. err clears when the next request is accepted, and a later run request retries the domain.
- R8: done is a single-cycle pulse after the last domain of a request. busy is high from the cycle after a request is accepted through the done cycle.
- R9: A request that arrives while busy is high is ignored.
- R10: ret_kb gives the RAM retained in standby. With cfg_keep[1:0] = 00 it is 8, with 01 it is 64, with 11 it is 96 and with 10 it is 40.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Writes cfg_keep and cfg_limit into the configuration registers |
| cfg_keep | input | N_DOM-2 | Keep bits; bit i belongs to domain i+2 |
| cfg_limit | input | TMO_W | Voltage-good wait limit |
| req | input | 1 | Mode change request strobe |
| req_stby | input | 1 | 1 = enter standby, 0 = run / wakeup |
| pwr_ok | input | N_DOM | Per-domain voltage-good |
| dom_sw_on | output | N_DOM | Per-domain supply switch |
| dom_clk_en | output | N_DOM | Per-domain clock enable |
| dom_rst_n | output | N_DOM | Per-domain active-low reset |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | End-of-request pulse |
| err | output | 1 | Voltage-good wait timed out |
| ret_kb | output | KB_W | Retained RAM size in standby, in KB |

## Verification
The bench uses the default build of four domains and an 8-bit limit. At run time it writes a limit of 5, so the voltage-good timeout comes within reach in a few cycles. A supply model in the bench raises pwr_ok three cycles after the switch closes, and it can hold one chosen domain's pwr_ok low. This lets the bench reach the timeout, the hold-in-reset state and the retry on the next run request. Every keep-bit combination is driven through standby and wakeup, and so are a run request with all keep bits clear and a request issued while busy.

// File: rtl/pds_pkg.sv
package pds_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_PICK, S_DCLK, S_DRST, S_DSW,
    S_USW, S_UWAIT, S_UCLK, S_URST, S_FIN
  } seq_st_e;

  typedef enum logic [2:0] {
    C_NONE, C_CLK_OFF, C_RST_ON, C_SW_OFF, C_SW_ON, C_CLK_ON, C_RST_OFF
  } dom_cmd_e;

endpackage

// File: rtl/pds_cfg.sv
module pds_cfg #(
  parameter int unsigned N_EXT    = 2,
  parameter int unsigned TMO_W    = 8,
  parameter int unsigned TMO_INIT = 16,
  parameter int unsigned KB_W     = 8,
  parameter int unsigned BASE_KB  = 8,
  parameter int unsigned EXT0_KB  = 56,
  parameter int unsigned EXT1_KB  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [N_EXT-1:0] keep_in,
  input  logic [TMO_W-1:0] limit_in,
  output logic [N_EXT-1:0] keep,
  output logic [TMO_W-1:0] limit,
  output logic [KB_W-1:0]  ret_kb
);

  function automatic int unsigned ext_kb(input int i);
    if (i == 0) return EXT0_KB;
    if (i == 1) return EXT1_KB;
    return 0;
  endfunction

  logic [N_EXT-1:0] keep_q;
  logic [TMO_W-1:0] limit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      keep_q  <= '1;
      limit_q <= TMO_W'(TMO_INIT);
    end else if (wr) begin
      keep_q  <= keep_in;
      limit_q <= limit_in;
    end
  end

  always_comb begin
    ret_kb = KB_W'(BASE_KB);
    for (int i = 0; i < int'(N_EXT); i++) begin
      if (keep_q[i]) ret_kb = ret_kb + KB_W'(ext_kb(i));
    end
  end

  assign keep  = keep_q;
  assign limit = limit_q;

endmodule

// File: rtl/pds_dom.sv
module pds_dom
  import pds_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sel,
  input  dom_cmd_e cmd,
  output logic     sw_on,
  output logic     clk_en,
  output logic     dom_rst_n
);

  logic sw_q, clk_q, rn_q;
  logic sw_d, clk_d, rn_d;
  logic upd;

  assign upd = sel && (cmd != C_NONE);

  always_comb begin
    sw_d  = sw_q;
    clk_d = clk_q;
    rn_d  = rn_q;
    case (cmd)
      C_CLK_OFF: clk_d = 1'b0;
      C_RST_ON:  rn_d  = 1'b0;
      C_SW_OFF:  sw_d  = 1'b0;
      C_SW_ON:   sw_d  = 1'b1;
      C_CLK_ON:  clk_d = 1'b1;
      C_RST_OFF: rn_d  = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q  <= 1'b1;
      clk_q <= 1'b1;
      rn_q  <= 1'b1;
    end else if (upd) begin
      sw_q  <= sw_d;
      clk_q <= clk_d;
      rn_q  <= rn_d;
    end
  end

  assign sw_on     = sw_q;
  assign clk_en    = clk_q;
  assign dom_rst_n = rn_q;

endmodule

// File: rtl/pds_fsm.sv
module pds_fsm
  import pds_pkg::*;
#(
  parameter int unsigned N_DOM = 4,
  parameter int unsigned TMO_W = 8,
  localparam int unsigned N_EXT = N_DOM - 2,
  localparam int unsigned IDX_W = $clog2(N_DOM)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             req_stby,
  input  logic [N_EXT-1:0] keep,
  input  logic [TMO_W-1:0] limit,
  input  logic [N_DOM-1:0] pwr_ok,
  input  logic [N_DOM-1:0] dom_sw,
  input  logic [N_DOM-1:0] dom_rn,
  output logic [IDX_W-1:0] cur_idx,
  output dom_cmd_e         cmd,
  output logic             busy,
  output logic             done,
  output logic             err
);

  seq_st_e          st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             dn_q, dn_d;
  logic [TMO_W-1:0] tcnt_q, tcnt_d;
  logic             err_q, err_d;
  logic             adv, last;
  logic [N_DOM-1:0] off_mask;

  always_comb begin
    off_mask    = '0;
    off_mask[1] = 1'b1;
    for (int d = 2; d < int'(N_DOM); d++) off_mask[d] = ~keep[d-2];
  end

  assign last = dn_q ? (idx_q == '0) : (idx_q == IDX_W'(N_DOM-1));

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    dn_d   = dn_q;
    tcnt_d = tcnt_q;
    err_d  = err_q;
    cmd    = C_NONE;
    adv    = 1'b0;
    case (st_q)
      S_IDLE: if (req) begin
        dn_d  = req_stby;
        idx_d = req_stby ? IDX_W'(N_DOM-1) : '0;
        err_d = 1'b0;
        st_d  = S_PICK;
      end
      S_PICK: begin
        if (dn_q) begin
          if (off_mask[idx_q] && dom_sw[idx_q]) st_d = S_DCLK;
          else adv = 1'b1;
        end else begin
          if (!dom_rn[idx_q]) st_d = S_USW;
          else adv = 1'b1;
        end
      end
      S_DCLK: begin cmd = C_CLK_OFF; st_d = S_DRST; end
      S_DRST: begin cmd = C_RST_ON;  st_d = S_DSW;  end
      S_DSW:  begin cmd = C_SW_OFF;  adv  = 1'b1;   end
      S_USW:  begin cmd = C_SW_ON; tcnt_d = '0; st_d = S_UWAIT; end
      S_UWAIT: begin
        if (pwr_ok[idx_q]) st_d = S_UCLK;
        else if (tcnt_q == limit) begin
          err_d = 1'b1;
          adv   = 1'b1;
        end else tcnt_d = tcnt_q + 1'b1;
      end
      S_UCLK: begin cmd = C_CLK_ON;  st_d = S_URST; end
      S_URST: begin cmd = C_RST_OFF; adv  = 1'b1;   end
      S_FIN:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
    if (adv) begin
      if (last) st_d = S_FIN;
      else begin
        idx_d = dn_q ? idx_q - 1'b1 : idx_q + 1'b1;
        st_d  = S_PICK;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      idx_q  <= '0;
      dn_q   <= 1'b0;
      tcnt_q <= '0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      dn_q   <= dn_d;
      tcnt_q <= tcnt_d;
      err_q  <= err_d;
    end
  end

  assign cur_idx = idx_q;
  assign busy    = (st_q != S_IDLE);
  assign done    = (st_q == S_FIN);
  assign err     = err_q;

endmodule

// File: rtl/pwr_dom_seq.sv
module pwr_dom_seq
  import pds_pkg::*;
#(
  parameter int unsigned N_DOM    = 4,
  parameter int unsigned TMO_W    = 8,
  parameter int unsigned TMO_INIT = 16,
  parameter int unsigned KB_W     = 8,
  parameter int unsigned BASE_KB  = 8,
  parameter int unsigned EXT0_KB  = 56,
  parameter int unsigned EXT1_KB  = 32,
  localparam int unsigned N_EXT   = N_DOM - 2,
  localparam int unsigned IDX_W   = $clog2(N_DOM)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [N_EXT-1:0] cfg_keep,
  input  logic [TMO_W-1:0] cfg_limit,
  input  logic             req,
  input  logic             req_stby,
  input  logic [N_DOM-1:0] pwr_ok,
  output logic [N_DOM-1:0] dom_sw_on,
  output logic [N_DOM-1:0] dom_clk_en,
  output logic [N_DOM-1:0] dom_rst_n,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [KB_W-1:0]  ret_kb
);

  logic [N_EXT-1:0] keep;
  logic [TMO_W-1:0] limit;
  logic [IDX_W-1:0] cur_idx;
  dom_cmd_e         cmd;

  pds_cfg #(
    .N_EXT(N_EXT), .TMO_W(TMO_W), .TMO_INIT(TMO_INIT), .KB_W(KB_W),
    .BASE_KB(BASE_KB), .EXT0_KB(EXT0_KB), .EXT1_KB(EXT1_KB)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .keep_in(cfg_keep),
    .limit_in(cfg_limit), .keep(keep), .limit(limit), .ret_kb(ret_kb)
  );

  pds_fsm #(.N_DOM(N_DOM), .TMO_W(TMO_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .req(req), .req_stby(req_stby),
    .keep(keep), .limit(limit), .pwr_ok(pwr_ok),
    .dom_sw(dom_sw_on), .dom_rn(dom_rst_n),
    .cur_idx(cur_idx), .cmd(cmd), .busy(busy), .done(done), .err(err)
  );

  for (genvar d = 0; d < int'(N_DOM); d++) begin : g_dom
    if (d == 0) begin : g_aon
      assign dom_sw_on[d]  = 1'b1;
      assign dom_clk_en[d] = 1'b1;
      assign dom_rst_n[d]  = 1'b1;
    end else begin : g_sw
      pds_dom u_dom (
        .clk(clk), .rst_n(rst_n),
        .sel(cur_idx == IDX_W'(d)), .cmd(cmd),
        .sw_on(dom_sw_on[d]), .clk_en(dom_clk_en[d]), .dom_rst_n(dom_rst_n[d])
      );
    end
  end

endmodule

// File: rtl/pds_chk.sv
module pds_chk #(
  parameter int unsigned N_DOM = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req,
  input logic [N_DOM-1:0] pwr_ok,
  input logic [N_DOM-1:0] dom_sw_on,
  input logic [N_DOM-1:0] dom_clk_en,
  input logic [N_DOM-1:0] dom_rst_n,
  input logic             busy,
  input logic             done,
  input logic             err
);

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  a_r7_err_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> busy);

  a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && req) |=> busy);

  for (genvar d = 1; d < int'(N_DOM); d++) begin : g_d
    a_r4_sw_off_last: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dom_sw_on[d]) |-> (!dom_clk_en[d] && !dom_rst_n[d]));

    a_r4_rst_after_clk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dom_rst_n[d]) |-> !dom_clk_en[d]);

    a_r5_clk_after_ok: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dom_clk_en[d]) |-> (dom_sw_on[d] && $past(pwr_ok[d])));

    a_r5_rst_release_last: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dom_rst_n[d]) |-> (dom_clk_en[d] && dom_sw_on[d]));
  end

endmodule

bind pwr_dom_seq pds_chk #(.N_DOM(N_DOM)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .pwr_ok(pwr_ok),
  .dom_sw_on(dom_sw_on), .dom_clk_en(dom_clk_en), .dom_rst_n(dom_rst_n),
  .busy(busy), .done(done), .err(err)
);

// File: tb/pwr_dom_seq_tb.sv
module pwr_dom_seq_tb;

  localparam int ND = 4;
  localparam int NE = ND - 2;

  typedef struct packed {
    logic [1:0] dom;
    logic [1:0] kind;  // 0 clk_en, 1 rst_n, 2 sw_on
    logic       val;
  } ev_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_wr = 1'b0;
  logic [NE-1:0] cfg_keep = '0;
  logic [7:0]    cfg_limit = 8'd16;
  logic          req = 1'b0;
  logic          req_stby = 1'b0;
  logic [ND-1:0] pwr_ok;
  logic [ND-1:0] dom_sw_on, dom_clk_en, dom_rst_n;
  logic          busy, done, err;
  logic [7:0]    ret_kb;

  int total = 0;
  int bad = 0;
  int done_cnt = 0;
  ev_t exp_q[$];

  logic [ND-1:0] fault = '0;
  logic [ND-1:0] okp1, okp2, okp3;

  logic [NE-1:0] m_keep;
  logic [ND-1:0] m_sw, m_up;
  logic          m_err;

  always #4 clk = ~clk;

  pwr_dom_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_keep(cfg_keep),
    .cfg_limit(cfg_limit), .req(req), .req_stby(req_stby), .pwr_ok(pwr_ok),
    .dom_sw_on(dom_sw_on), .dom_clk_en(dom_clk_en), .dom_rst_n(dom_rst_n),
    .busy(busy), .done(done), .err(err), .ret_kb(ret_kb)
  );

  // supply model: voltage good three cycles after the switch closes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      okp1 <= '1; okp2 <= '1; okp3 <= '1;
    end else begin
      okp1 <= dom_sw_on & ~fault;
      okp2 <= okp1 & dom_sw_on & ~fault;
      okp3 <= okp2 & dom_sw_on & ~fault;
    end
  end
  assign pwr_ok = okp3 & dom_sw_on & ~fault;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pop expected events as outputs change
  logic [ND-1:0] p_sw, p_clk, p_rn;
  always @(negedge clk) begin
    if (!rst_n) begin
      p_sw = dom_sw_on; p_clk = dom_clk_en; p_rn = dom_rst_n;
    end else begin
      if (done) done_cnt++;
      for (int d = 0; d < ND; d++) begin
        for (int k = 0; k < 3; k++) begin
          logic pv, cv;
          pv = (k == 0) ? p_clk[d] : (k == 1) ? p_rn[d] : p_sw[d];
          cv = (k == 0) ? dom_clk_en[d] : (k == 1) ? dom_rst_n[d] : dom_sw_on[d];
          if (pv != cv) begin
            ev_t got;
            got.dom = 2'(d); got.kind = 2'(k); got.val = cv;
            if (exp_q.size() == 0) chk(1'b0, "R4 R5 R6 R9 unexpected output change", int'(got), -1);
            else begin
              ev_t e;
              e = exp_q.pop_front();
              chk(got == e, "R4 R5 event order (dom,kind,val)", int'(got), int'(e));
            end
          end
        end
      end
      p_sw = dom_sw_on; p_clk = dom_clk_en; p_rn = dom_rst_n;
    end
  end

  function automatic ev_t mk(input int d, input int k, input bit v);
    ev_t e;
    e.dom = 2'(d); e.kind = 2'(k); e.val = v;
    return e;
  endfunction

  task automatic cfg(input logic [NE-1:0] kp, input logic [7:0] lim);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_keep = kp; cfg_limit = lim;
    @(negedge clk);
    cfg_wr = 1'b0;
    m_keep = kp;
  endtask

  // driver: compute expected events from the requirements, then issue
  task automatic run_req(input bit stby, input bool_extra);
    int start_done;
    bit seen;
    m_err = 1'b0;
    if (stby) begin
      for (int d = ND-1; d >= 1; d--) begin
        bit off;
        off = (d == 1) || !m_keep[d-2];
        if (off && m_sw[d]) begin
          exp_q.push_back(mk(d, 0, 1'b0));
          exp_q.push_back(mk(d, 1, 1'b0));
          exp_q.push_back(mk(d, 2, 1'b0));
          m_sw[d] = 1'b0; m_up[d] = 1'b0;
        end
      end
    end else begin
      for (int d = 0; d < ND; d++) begin
        if (!m_up[d]) begin
          if (!m_sw[d]) exp_q.push_back(mk(d, 2, 1'b1));
          m_sw[d] = 1'b1;
          if (fault[d]) m_err = 1'b1;
          else begin
            exp_q.push_back(mk(d, 0, 1'b1));
            exp_q.push_back(mk(d, 1, 1'b1));
            m_up[d] = 1'b1;
          end
        end
      end
    end
    start_done = done_cnt;
    @(negedge clk);
    req = 1'b1; req_stby = stby;
    @(negedge clk);
    req = 1'b0;
    chk(busy == 1'b1, "R8 busy after accept", int'(busy), 1);
    if (bool_extra) begin
      @(negedge clk);
      req = 1'b1; req_stby = ~stby;
      @(negedge clk);
      req = 1'b0;
    end
    seen = 1'b0;
    for (int i = 0; i < 400; i++) begin
      if (done) begin seen = 1'b1; break; end
      @(negedge clk);
    end
    chk(seen, "R8 done seen", int'(seen), 1);
    chk(err == m_err, "R7 err at done", int'(err), int'(m_err));
    @(negedge clk);
    chk(done == 1'b0, "R8 done single cycle", int'(done), 0);
    chk(busy == 1'b0, "R8 idle after done", int'(busy), 0);
    chk(exp_q.size() == 0, "R4 R5 all expected events seen", exp_q.size(), 0);
    chk(dom_sw_on == m_sw, "R3 R5 supply state", int'(dom_sw_on), int'(m_sw));
    chk(dom_rst_n == m_up && dom_clk_en == m_up, "R5 R7 clock/reset state",
        int'({dom_clk_en, dom_rst_n}), int'({m_up, m_up}));
    chk(dom_sw_on[0] && dom_clk_en[0] && dom_rst_n[0], "R2 domain 0 on",
        int'({dom_sw_on[0], dom_clk_en[0], dom_rst_n[0]}), 7);
    if (bool_extra) begin
      repeat (30) @(negedge clk);
      chk(done_cnt == start_done + 1, "R9 extra request ignored (done count)",
          done_cnt - start_done, 1);
      chk(busy == 1'b0, "R9 still idle", int'(busy), 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m_keep = '1; m_sw = '1; m_up = '1; m_err = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(dom_sw_on == '1 && dom_clk_en == '1 && dom_rst_n == '1, "R1 all domains up",
        int'({dom_sw_on, dom_clk_en, dom_rst_n}), 4095);
    chk(!done && !err && !busy, "R1 flags low", int'({done, err, busy}), 0);
    chk(ret_kb == 8'd96, "R1 R10 reset keep bits", int'(ret_kb), 96);

    // R10 retained size per keep combination
    cfg(2'b00, 8'd16); @(negedge clk); chk(ret_kb == 8'd8,  "R10 keep 00", int'(ret_kb), 8);
    cfg(2'b01, 8'd16); @(negedge clk); chk(ret_kb == 8'd64, "R10 keep 01", int'(ret_kb), 64);
    cfg(2'b11, 8'd16); @(negedge clk); chk(ret_kb == 8'd96, "R10 keep 11", int'(ret_kb), 96);
    cfg(2'b10, 8'd16); @(negedge clk); chk(ret_kb == 8'd40, "R10 keep 10", int'(ret_kb), 40);

    // R6: run request with keep clear changes nothing
    cfg(2'b00, 8'd16);
    run_req(1'b0, 1'b0);

    // R3 R4: domain 2 kept, domain 3 off
    cfg(2'b01, 8'd16);
    run_req(1'b1, 1'b0);
    run_req(1'b0, 1'b0);   // R5

    // only domain 3 kept
    cfg(2'b10, 8'd16);
    run_req(1'b1, 1'b0);
    run_req(1'b0, 1'b0);

    // both kept: only domain 1 goes down
    cfg(2'b11, 8'd16);
    run_req(1'b1, 1'b0);
    run_req(1'b0, 1'b0);

    // all switchable domains down; R9 extra request during wakeup
    cfg(2'b00, 8'd16);
    run_req(1'b1, 1'b0);
    run_req(1'b0, 1'b1);

    // R7 timeout on domain 2
    cfg(2'b00, 8'd5);
    run_req(1'b1, 1'b0);
    fault = 4'b0100;
    run_req(1'b0, 1'b0);
    chk(dom_sw_on[2] && !dom_clk_en[2] && !dom_rst_n[2], "R7 held in reset",
        int'({dom_sw_on[2], dom_clk_en[2], dom_rst_n[2]}), 4);
    fault = '0;
    run_req(1'b0, 1'b0);   // R7 retry and err cleared
    chk(err == 1'b0, "R7 err cleared", int'(err), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule